// File: doc/BRIEF.md
# Survivor Decision Buffer with Token-Tracked Hand-Over

This block sits between the add-compare-select array of a 64-state trellis decoder and its traceback memory. Each fast-clock cycle in which it is active, it takes in one vector of survivor decision bits, one bit per trellis state. It keeps the eight most recent vectors in a chain of registers in which each stage talks only to its neighbour. Once a group of eight vectors has lined up, the block raises a one-cycle transfer strobe and the downstream memory captures the whole 64x8 chunk at that clock edge.

A short control chain of flag bits runs alongside the data chain. A single set flag enters it together with the first vector of a group and moves one place per active cycle. The flag therefore marks how far that group has travelled. When the flag reaches the last place, it produces the transfer strobe. One place earlier it produces an early strobe that starts the first stage of the global-minimum search.

The block drives a clock-enable output that stands in for its gated clock, and every state update depends on it. In normal operation the block freezes whenever its accept enable is low. In the two flush modes it keeps running until the group in flight has been handed over, even if the accept enable is low. The accept enable is expected to be the add-compare-select enable delayed by one register upstream.

Top module: `decision_buffer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every chunk slice and every control flag is cleared. After reset, with `acc_en` low, `gate_en`, `xfer_strobe` and `minsel_early` are 0 and `chunk` is all zero.
- R2: On each clock edge where `gate_en` is 1, `dec_vec` is written into slice 0 and each slice j moves into slice j+1. Slice j occupies bits [j*STATES +: STATES] of `chunk`.
- R3: A group starts on an active edge that finds no flag in the first DEPTH-1 control places and that has `acc_en` high. `xfer_strobe` is 1 in the next cycle that has `gate_en` high, once DEPTH-1 further active edges have passed. It is never high in two consecutive cycles.
- R4: While `xfer_strobe` is 1, slice DEPTH-1 holds the first vector of the group and slice 0 holds the last one. In general, slice j holds the vector accepted DEPTH-1-j active edges after the first.
- R5: `minsel_early` is 1 in the active cycle in which the group has passed exactly DEPTH-2 active edges after its start, so it comes one active cycle before `xfer_strobe`. The two strobes are never high together, and both are 0 whenever `gate_en` is 0.
- R6: With `acc_en` held high, `xfer_strobe` pulses once every DEPTH cycles. The edge that completes a transfer also starts the next group, so consecutive chunks contain consecutive vectors with none lost.
- R7: In normal mode (`mode_in[0]` = 0), `gate_en` follows `acc_en`. While it is low, `chunk` and all flags keep their values and both strobes are 0. A group in flight resumes where it stopped.
- R8: In flush mode (`mode_in[0]` = 1), `gate_en` stays 1 while a group is in flight, whatever `acc_en` is. The slices keep shifting in `dec_vec`, up to and including the transfer edge. No new group starts while `acc_en` is low.
- R9: In flush mode with no group in flight and `acc_en` low, `gate_en` is 0 and `chunk` holds.
- R10: `mode_in` encodes 2'b00 normal data, 2'b01 signal-field flush and 2'b11 last-data flush. Only bit 0 selects flushing, so the unused code 2'b10 behaves as normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast decoder clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Accept enable, a decision vector is present this cycle |
| mode_in | input | 2 | Operating mode code (see R10) |
| dec_vec | input | STATES | Survivor decision vector, one bit per state |
| chunk | output | STATES*DEPTH | All slices, slice j at bits [j*STATES +: STATES] |
| xfer_strobe | output | 1 | Chunk is complete, the traceback memory captures it at this edge |
| minsel_early | output | 1 | Start strobe for the first minimum-search stage |
| gate_en | output | 1 | Clock enable of this block |

## Verification
The three strobe outputs are combinational on the current flags and inputs. They are therefore checked in the same cycle in which the inputs are applied, one nanosecond after the falling edge at which the bench drives them. `chunk` is registered, so the effect of a vector shows one edge after the active cycle that accepted it. The strobes of a group fall DEPTH-2 and DEPTH-1 active edges after the edge that started it, and frozen cycles are not counted. The bench keeps a model of the slices and of the group position that advances only on cycles it predicts as active. It compares the full chunk every cycle and the slice order in every strobe cycle, across sweeps of mode, burst length and gap pattern.

// File: rtl/dbuf_pkg.sv
// Package: shared mode codes for the decision buffer.
// Assumes the upstream controller drives the two-bit mode in step with the data.
package dbuf_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'b00,
        MODE_SIGNAL  = 2'b01,
        MODE_SPARE   = 2'b10,
        MODE_LASTDAT = 2'b11
    } dbuf_mode_e;

    // Flushing is selected by bit 0 alone.
    function automatic logic is_flush(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/dbuf_gate.sv
// Module: dbuf_gate
// Computes the block clock enable. In normal mode the block runs only while
// vectors arrive. In flush mode it also runs while a group is in flight.
// Assumes busy is the OR of all control flags, taken from registers.
module dbuf_gate
    import dbuf_pkg::*;
(
    input  logic       acc_en,
    input  logic [1:0] mode_in,
    input  logic       busy,
    output logic       gate_en
);

    logic flushing;

    // Purpose: decode the mode into a flush request.
    always_comb begin
        flushing = is_flush(mode_in);
    end

    // Purpose: combine arrival and flush hold into the enable.
    always_comb begin
        gate_en = acc_en | (flushing & busy);
    end

endmodule

// File: rtl/dbuf_token.sv
// Module: dbuf_token
// Control chain of DEPTH flag bits that tracks the data front. The first
// place loads acc_en only when no flag sits in places 0..DEPTH-2. Otherwise it
// loads zero, so at most one group is tracked at a time.
// Assumes adv is the block clock enable; the chain is frozen while it is low.
module dbuf_token #(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             acc_en,
    output logic [DEPTH-1:0] flags,
    output logic             busy
);

    localparam int LOW_W = DEPTH - 1;

    logic slot_free;
    logic head_in;

    // Purpose: a new group may start when the front places are empty.
    always_comb begin
        slot_free = (flags[LOW_W-1:0] == '0);
        head_in   = slot_free & acc_en;
        busy      = |flags;
    end

    // Purpose: shift the flag chain on each active edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else if (adv) begin
            flags <= {flags[DEPTH-2:0], head_in};
        end
    end

endmodule

// File: rtl/dbuf_store.sv
// Module: dbuf_store
// Shift chain of DEPTH registers of STATES bits each. Each stage loads only
// from its neighbour. Slice 0 takes the new vector.
// Assumes adv is the block clock enable.
module dbuf_store #(
    parameter int STATES = 64,
    parameter int DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic [STATES-1:0]         vec_in,
    output logic [STATES*DEPTH-1:0]   slices
);

    logic [STATES-1:0] stage_q [DEPTH];

    // Purpose: first stage captures the incoming decision vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q[0] <= '0;
        end else if (adv) begin
            stage_q[0] <= vec_in;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Purpose: stage g takes the value of stage g-1.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (adv) begin
                stage_q[g] <= stage_q[g-1];
            end
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_pack
        assign slices[k*STATES +: STATES] = stage_q[k];
    end

endmodule

// File: rtl/decision_buffer.sv
// Module: decision_buffer (top)
// Buffers DEPTH survivor vectors and strobes their hand-over as one chunk.
// Strobes are qualified by the clock enable, so each one is a single active
// cycle. Assumes acc_en is the add-compare-select enable delayed by one
// register, and that MINSEL_TAP is less than DEPTH-1.
module decision_buffer #(
    parameter int STATES     = 64,
    parameter int DEPTH      = 8,
    parameter int MINSEL_TAP = DEPTH - 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic [1:0]              mode_in,
    input  logic [STATES-1:0]       dec_vec,
    output logic [STATES*DEPTH-1:0] chunk,
    output logic                    xfer_strobe,
    output logic                    minsel_early,
    output logic                    gate_en
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] flags;
    logic             busy;

    dbuf_gate u_gate (
        .acc_en  (acc_en),
        .mode_in (mode_in),
        .busy    (busy),
        .gate_en (gate_en)
    );

    dbuf_token #(.DEPTH(DEPTH)) u_token (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (gate_en),
        .acc_en (acc_en),
        .flags  (flags),
        .busy   (busy)
    );

    dbuf_store #(.STATES(STATES), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (gate_en),
        .vec_in (dec_vec),
        .slices (chunk)
    );

    // Purpose: derive the qualified transfer and early-search strobes.
    always_comb begin
        xfer_strobe  = flags[LAST] & gate_en;
        minsel_early = flags[MINSEL_TAP] & gate_en;
    end

endmodule

// File: rtl/dbuf_checker.sv
// Module: dbuf_checker
// Temporal checks on the decision buffer ports, attached through bind.
module dbuf_checker #(
    parameter int STATES = 64,
    parameter int DEPTH  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_en,
    input logic [1:0]              mode_in,
    input logic [STATES-1:0]       dec_vec,
    input logic [STATES*DEPTH-1:0] chunk,
    input logic                    xfer_strobe,
    input logic                    minsel_early,
    input logic                    gate_en
);

    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en |=> chunk[STATES-1:0] == $past(dec_vec));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |=> !xfer_strobe);

    assert_early_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        minsel_early |=> (xfer_strobe == gate_en));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({xfer_strobe, minsel_early}));

    assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_en |=> $stable(chunk));

    assert_normal_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_in[0] && !acc_en) |-> (!xfer_strobe && !minsel_early));

endmodule

bind decision_buffer dbuf_checker #(.STATES(STATES), .DEPTH(DEPTH)) u_dbuf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_en       (acc_en),
    .mode_in      (mode_in),
    .dec_vec      (dec_vec),
    .chunk        (chunk),
    .xfer_strobe  (xfer_strobe),
    .minsel_early (minsel_early),
    .gate_en      (gate_en)
);

// File: tb/decision_buffer_test.sv
module decision_buffer_test;

    localparam int ST = 64;
    localparam int DP = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_en = 1'b0;
    logic [1:0]        mode_in = 2'b00;
    logic [ST-1:0]     dec_vec = '0;
    logic [ST*DP-1:0]  chunk;
    logic              xfer_strobe;
    logic              minsel_early;
    logic              gate_en;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state, defined by the requirements
    logic [ST-1:0] ref_s [DP];
    bit            grp = 0;
    int            pos = 0;
    logic [31:0]   seed = 32'h1234_5678;

    decision_buffer #(.STATES(ST), .DEPTH(DP)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .mode_in(mode_in),
        .dec_vec(dec_vec), .chunk(chunk), .xfer_strobe(xfer_strobe),
        .minsel_early(minsel_early), .gate_en(gate_en)
    );

    always #10 clk = ~clk;

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_slices(input string tag);
        for (int j = 0; j < DP; j++) begin
            total++;
            if (chunk[j*ST +: ST] !== ref_s[j]) begin
                bad++;
                $display("FAIL %s slice%0d actual=%h expected=%h", tag, j,
                         chunk[j*ST +: ST], ref_s[j]);
            end
        end
    endtask

    function automatic logic [ST-1:0] next_vec();
        seed = seed * 32'd1103515245 + 32'd12345;
        return {seed, ~seed ^ 32'h5A5A_0F0F};
    endfunction

    // one cycle: drive at falling edge, check, then advance the model for the edge
    task automatic step(input logic fe, input logic [1:0] md, input string tag);
        logic act;
        @(negedge clk);
        acc_en  = fe;
        mode_in = md;
        dec_vec = next_vec();
        #1;
        act = fe | (md[0] & grp);
        chk1(tag, "gate_en", gate_en, act);
        chk1("R3", "xfer_strobe", xfer_strobe, act & grp & (pos == DP-1));
        chk1("R5", "minsel_early", minsel_early, act & grp & (pos == DP-2));
        if (act & grp & (pos == DP-1)) chk_slices("R4");
        else chk_slices("R2");
        if (act) begin
            for (int j = DP-1; j > 0; j--) ref_s[j] = ref_s[j-1];
            ref_s[0] = dec_vec;
            if (grp && pos != DP-1) pos++;
            else if (fe) begin grp = 1; pos = 0; end
            else grp = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_en = 1'b0; mode_in = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int j = 0; j < DP; j++) ref_s[j] = '0;
        grp = 0; pos = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        step(1'b0, 2'b00, "R1");
        step(1'b0, 2'b01, "R1");
        // R6: continuous streaming
        for (int i = 0; i < 26; i++) step(1'b1, 2'b00, "R6");
        // R7: normal mode with gaps freezes mid-group
        for (int i = 0; i < 48; i++) step((i % 3) != 0, 2'b00, "R7");
        for (int i = 0; i < 48; i++) step((i % 5) > 1, 2'b00, "R7");
        // R10: spare code acts as normal
        for (int i = 0; i < 40; i++) step((i % 4) != 0, 2'b10, "R10");
        // R8: signal-field flush after a short burst
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 2'b01, "R8");
        for (int i = 0; i < 12; i++) step(1'b0, 2'b01, "R8");
        // R9: idle flush with nothing in flight
        for (int i = 0; i < 6; i++) step(1'b0, 2'b01, "R9");
        // R8: last-data flush after longer burst
        for (int i = 0; i < 19; i++) step(1'b1, 2'b11, "R8");
        for (int i = 0; i < 12; i++) step(1'b0, 2'b11, "R8");
        // sweep over mode and burst length
        for (int m = 0; m < 4; m++) begin
            for (int len = 1; len <= 17; len++) begin
                for (int i = 0; i < len; i++) step(1'b1, 2'(m), (m % 2) ? "R8" : "R7");
                for (int i = 0; i < 10; i++) step(1'b0, 2'(m), (m % 2) ? "R8" : "R10");
            end
        end
        // reset mid-group returns to the cleared state
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00, "R6");
        do_reset();
        step(1'b0, 2'b00, "R1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule